// File: doc/BRIEF.md
# Byte-Pair Width Converter for an 18-Bit FIFO Core

This block sits on both sides of a FIFO core whose storage word is two 9-bit bytes wide. On the write side it accepts either full 18-bit words or single 9-bit bytes. In byte mode it holds the first byte of each pair and hands the core one packed word when the second byte arrives. On the read side it delivers either whole core words or single bytes. In byte mode it fetches one core word, returns one half on that read and the other half on the next read, with no second fetch.

The two sides are configured independently. Write width, read width and byte order are sampled only while master reset is high. Byte order decides whether the first byte of a pair sits in the upper half (bits 17:9) or the lower half (bits 8:0) of the core word. Unpacking uses the same rule in reverse, so bytes leave in the order they arrived when both sides are in byte mode. A partial reset drops any half-built pair and any half-consumed word and keeps the configuration.

The core's storage and its status flags are outside this block. The core is assumed to accept a word on every `core_we` cycle and to return the fetched word on `core_rdata` in the cycle after `core_re`. The user never reads an empty core.

Top module: `wc_width_conv`

## Requirements
- R1: While master reset is high and in the cycle after it, `core_we`, `core_re`, `rd_valid`, `core_wdata` and `rd_data` are all 0.
- R2: `in_wide_sel`, `out_wide_sel` and `big_end_sel` are sampled only on clock edges where `mrst` is high. Changing them at any other time has no effect on packing, unpacking or byte order.
- R3: With a wide input (`in_wide_sel`=1 at reset), every write presents `wr_data` to the core. `core_we` is high with that word in the cycle after the write.
- R4: With a narrow input (`in_wide_sel`=0), each write carries one byte in `wr_data[8:0]`. The first byte of a pair produces no core write. The second produces `core_we` with the packed word in the cycle after it, so `core_we` is never high in two consecutive cycles.
- R5: With big-endian order (`big_end_sel`=1), the first byte of a pair is placed in core bits 17:9 and the second in bits 8:0. With little-endian order (`big_end_sel`=0), the first byte goes to bits 8:0 and the second to bits 17:9.
- R6: Every `rd_en` is answered by `rd_valid` with its data two clock edges later. `core_re` is never high without `rd_en`. With a wide output, each read fetches one core word (`core_re` in the same cycle) and returns all 18 bits.
- R7: With a narrow output (`out_wide_sel`=0), `core_re` is raised only on the first read of each pair. The two reads return the two halves on `rd_data[8:0]`, in the order given by R5, and `rd_data[17:9]` is 0.
- R8: A partial reset discards a staged first byte and the unpack position, so the next byte starts a new pair and the next read fetches a new core word. The latched configuration is kept.
- R9: With both sides narrow, bytes leave in the order they were written, under either byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high; latches configuration |
| prst | input | 1 | Partial reset, synchronous, active high; keeps configuration |
| in_wide_sel | input | 1 | 1 = 18-bit write side, 0 = 9-bit; sampled in master reset |
| out_wide_sel | input | 1 | 1 = 18-bit read side, 0 = 9-bit; sampled in master reset |
| big_end_sel | input | 1 | 1 = first byte in upper half, 0 = lower half; sampled in master reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 18 | Write word, or byte in bits 8:0 |
| core_we | output | 1 | Write strobe to the core |
| core_wdata | output | 18 | Packed word to the core |
| core_re | output | 1 | Fetch request to the core |
| core_rdata | input | 18 | Core word, valid the cycle after core_re |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 18 | Read word, or byte in bits 8:0 |
| rd_valid | output | 1 | rd_data holds the result of a read |

## Verification
The hardest states to reach are a partial reset that arrives while a pair is half built on the write side, and one that arrives between the two byte reads of one core word. The first only shows if the discarded byte could have leaked into a later word. The second only shows if the next read would have returned the leftover half instead of fetching. The stimulus writes one lone byte, pulses partial reset, and writes two more bytes; the single resulting core word must hold only those two. On the read side it queues two distinct words, reads once, pulses partial reset, and reads again; the result must be the first byte of the second word. In both runs the read-back width and order show that the configuration survived.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {
    ORD_LITTLE = 1'b0,
    ORD_BIG    = 1'b1
  } order_e;

  typedef struct packed {
    logic   wide;
    order_e order;
  } side_cfg_t;
endpackage

// File: rtl/wc_cfg_latch.sv
module wc_cfg_latch
  import wc_pkg::*;
(
  input  logic      clk,
  input  logic      mrst,
  input  logic      wide_pin,
  input  logic      order_pin,
  output side_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (mrst) begin
      cfg.wide  <= wide_pin;
      cfg.order <= order_pin ? ORD_BIG : ORD_LITTLE;
    end
  end
endmodule

// File: rtl/wc_packer.sv
module wc_packer
  import wc_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_all,
  input  side_cfg_t         cfg,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              core_we,
  output logic [WORD_W-1:0] core_wdata
);
  logic              have_first_q;
  logic [BYTE_W-1:0] first_q;
  logic [BYTE_W-1:0] in_byte;

  assign in_byte = wr_data[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst_all) begin
      have_first_q <= 1'b0;
      first_q      <= '0;
      core_we      <= 1'b0;
      core_wdata   <= '0;
    end else begin
      core_we <= 1'b0;
      if (wr_en) begin
        if (cfg.wide) begin
          core_we    <= 1'b1;
          core_wdata <= wr_data;
        end else if (!have_first_q) begin
          first_q      <= in_byte;
          have_first_q <= 1'b1;
        end else begin
          have_first_q <= 1'b0;
          core_we      <= 1'b1;
          if (cfg.order == ORD_BIG) core_wdata <= {first_q, in_byte};
          else                      core_wdata <= {in_byte, first_q};
        end
      end
    end
  end
endmodule

// File: rtl/wc_unpacker.sv
module wc_unpacker
  import wc_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_all,
  input  side_cfg_t         cfg,
  input  logic              rd_en,
  output logic              core_re,
  input  logic [WORD_W-1:0] core_rdata,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              half_q;
  logic              pend_q;
  logic              pend_fetch_q;
  logic              pend_second_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] word_sel;
  logic [BYTE_W-1:0] hi_byte;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] byte_sel;
  logic              take_hi;

  assign core_re = rd_en && !rst_all && (cfg.wide || !half_q);

  always_comb begin
    word_sel = pend_fetch_q ? core_rdata : hold_q;
    hi_byte  = word_sel[WORD_W-1:BYTE_W];
    lo_byte  = word_sel[BYTE_W-1:0];
    take_hi  = (cfg.order == ORD_BIG) ? !pend_second_q : pend_second_q;
    byte_sel = take_hi ? hi_byte : lo_byte;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      half_q        <= 1'b0;
      pend_q        <= 1'b0;
      pend_fetch_q  <= 1'b0;
      pend_second_q <= 1'b0;
      hold_q        <= '0;
      rd_data       <= '0;
      rd_valid      <= 1'b0;
    end else begin
      pend_q        <= rd_en;
      pend_fetch_q  <= core_re;
      pend_second_q <= !cfg.wide && half_q;
      if (rd_en && !cfg.wide) half_q <= !half_q;
      rd_valid <= pend_q;
      if (pend_q) begin
        if (pend_fetch_q) hold_q <= core_rdata;
        if (cfg.wide) rd_data <= word_sel;
        else          rd_data <= {{BYTE_W{1'b0}}, byte_sel};
      end
    end
  end
endmodule

// File: rtl/wc_width_conv.sv
module wc_width_conv
  import wc_pkg::*;
#(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              in_wide_sel,
  input  logic              out_wide_sel,
  input  logic              big_end_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              core_we,
  output logic [WORD_W-1:0] core_wdata,
  output logic              core_re,
  input  logic [WORD_W-1:0] core_rdata,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  side_cfg_t wr_cfg;
  side_cfg_t rd_cfg;
  logic      rst_all;

  assign rst_all = mrst || prst;

  wc_cfg_latch wr_cfg_i (
    .clk(wr_clk), .mrst(mrst), .wide_pin(in_wide_sel),
    .order_pin(big_end_sel), .cfg(wr_cfg)
  );

  wc_cfg_latch rd_cfg_i (
    .clk(rd_clk), .mrst(mrst), .wide_pin(out_wide_sel),
    .order_pin(big_end_sel), .cfg(rd_cfg)
  );

  wc_packer #(.BYTE_W(BYTE_W)) pack_i (
    .clk(wr_clk), .rst_all(rst_all), .cfg(wr_cfg),
    .wr_en(wr_en), .wr_data(wr_data),
    .core_we(core_we), .core_wdata(core_wdata)
  );

  wc_unpacker #(.BYTE_W(BYTE_W)) unpack_i (
    .clk(rd_clk), .rst_all(rst_all), .cfg(rd_cfg),
    .rd_en(rd_en), .core_re(core_re), .core_rdata(core_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/wc_width_conv_chk.sv
module wc_width_conv_chk #(
  parameter int BYTE_W = 9,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              mrst,
  input logic              prst,
  input logic              in_wide_sel,
  input logic              out_wide_sel,
  input logic              wr_en,
  input logic              core_we,
  input logic              rd_en,
  input logic              core_re,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data
);
  logic mon_in_wide;
  logic mon_out_wide;

  always_ff @(posedge wr_clk) if (mrst) mon_in_wide <= in_wide_sel;
  always_ff @(posedge rd_clk) if (mrst) mon_out_wide <= out_wide_sel;

  // R3
  core_we_cause_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
    core_we |-> $past(wr_en));

  // R4
  narrow_pair_gap_chk: assert property (@(posedge wr_clk) disable iff (mrst || prst)
    (!mon_in_wide && core_we) |=> !core_we);

  // R6
  fetch_needs_read_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
    core_re |-> rd_en);

  // R6
  read_latency_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
    rd_valid |-> $past(rd_en, 2));

  // R7
  narrow_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (mrst || prst)
    (!mon_out_wide && rd_valid) |-> (rd_data[WORD_W-1:BYTE_W] == '0));
endmodule

bind wc_width_conv wc_width_conv_chk #(.BYTE_W(BYTE_W)) chk_i (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
  .in_wide_sel(in_wide_sel), .out_wide_sel(out_wide_sel),
  .wr_en(wr_en), .core_we(core_we), .rd_en(rd_en), .core_re(core_re),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/wc_width_conv_tb_top.sv
module wc_width_conv_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0;
  logic in_wide_sel = 1'b0, out_wide_sel = 1'b0, big_end_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] core_rdata = '0;
  logic core_we, core_re, rd_valid;
  logic [W-1:0] core_wdata, rd_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mem[$];
  logic [W-1:0] wlog[$];
  logic [W-1:0] rlog[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_width_conv dut_i (
    .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .prst(prst),
    .in_wide_sel(in_wide_sel), .out_wide_sel(out_wide_sel), .big_end_sel(big_end_sel),
    .wr_en(wr_en), .wr_data(wr_data), .core_we(core_we), .core_wdata(core_wdata),
    .core_re(core_re), .core_rdata(core_rdata), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Core model: stores words, returns a fetched word the cycle after core_re.
  always @(posedge clk) begin
    if (core_re && mem.size() > 0) core_rdata <= mem.pop_front();
  end

  always @(negedge clk) begin
    if (core_we) begin
      mem.push_back(core_wdata);
      wlog.push_back(core_wdata);
    end
    if (rd_valid) rlog.push_back(rd_data);
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_mrst(input logic iw, input logic ow, input logic be);
    @(negedge clk);
    in_wide_sel = iw; out_wide_sel = ow; big_end_sel = be; mrst = 1'b1;
    idle(2);
    mrst = 1'b0;
    mem.delete(); wlog.delete(); rlog.delete();
  endtask

  task automatic pulse_prst();
    @(negedge clk); prst = 1'b1;
    @(negedge clk); prst = 1'b0;
  endtask

  // Returns at the negedge after the write edge.
  task automatic wr(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Returns fetch request seen during the read cycle.
  task automatic rd(output logic fetched);
    @(negedge clk); rd_en = 1'b1;
    #1 fetched = core_re;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 core_we", {17'd0, core_we}, 18'd0);
    check("R1 core_re", {17'd0, core_re}, 18'd0);
    check("R1 rd_valid", {17'd0, rd_valid}, 18'd0);
    check("R1 core_wdata", core_wdata, 18'd0);
    check("R1 rd_data", rd_data, 18'd0);
  endtask

  task automatic t_wide();
    logic f;
    do_mrst(1'b1, 1'b1, 1'b1);
    wr(18'h2A5C3);
    check("R3 core_we after write", {17'd0, core_we}, 18'd1);
    check("R3 core_wdata", core_wdata, 18'h2A5C3);
    wr(18'h15A3C);
    check("R3 second word", core_wdata, 18'h15A3C);
    // exact read latency
    @(negedge clk); rd_en = 1'b1;
    #1 check("R6 core_re with rd_en", {17'd0, core_re}, 18'd1);
    @(negedge clk); rd_en = 1'b0;
    check("R6 rd_valid not yet", {17'd0, rd_valid}, 18'd0);
    @(negedge clk);
    check("R6 rd_valid after two edges", {17'd0, rd_valid}, 18'd1);
    check("R6 wide data", rd_data, 18'h2A5C3);
    rd(f);
    check("R6 second fetch", {17'd0, f}, 18'd1);
    idle(3);
    check("R6 read count", 18'(rlog.size()), 18'd2);
    if (rlog.size() == 2) check("R6 second word", rlog[1], 18'h15A3C);
  endtask

  task automatic t_narrow_in(input logic be);
    logic f;
    logic [W-1:0] exp;
    exp = be ? {9'h1A5, 9'h0C3} : {9'h0C3, 9'h1A5};
    do_mrst(1'b0, 1'b1, be);
    wr({9'h1FF, 9'h1A5});
    check("R4 no write on first byte", {17'd0, core_we}, 18'd0);
    wr({9'h000, 9'h0C3});
    check("R4 write on second byte", {17'd0, core_we}, 18'd1);
    check(be ? "R5 big-endian pack" : "R5 little-endian pack", core_wdata, exp);
    rd(f);
    idle(3);
    check("R4 one core word", 18'(wlog.size()), 18'd1);
    if (rlog.size() > 0) check("R5 word read back", rlog[0], exp);
    else check("R5 word read back", 18'h3FFFF, exp);
  endtask

  task automatic t_narrow_out(input logic be);
    logic f1, f2;
    logic [W-1:0] first, second;
    first  = be ? 18'h155 : 18'h0AA;
    second = be ? 18'h0AA : 18'h155;
    do_mrst(1'b1, 1'b0, be);
    wr({9'h155, 9'h0AA});
    rd(f1);
    rd(f2);
    check("R7 first read fetches", {17'd0, f1}, 18'd1);
    check("R7 second read no fetch", {17'd0, f2}, 18'd0);
    idle(3);
    check("R7 two bytes out", 18'(rlog.size()), 18'd2);
    if (rlog.size() == 2) begin
      check("R7 first byte", rlog[0], first);
      check("R7 second byte", rlog[1], second);
    end
  endtask

  task automatic t_narrow_both(input logic be);
    logic f;
    do_mrst(1'b0, 1'b0, be);
    for (int i = 1; i <= 4; i++) wr(18'(9'h100 + i));
    for (int i = 0; i < 4; i++) rd(f);
    idle(3);
    check("R9 byte count", 18'(rlog.size()), 18'd4);
    for (int i = 0; i < 4; i++)
      if (i < rlog.size()) check("R9 byte order kept", rlog[i], 18'(9'h101 + i));
  endtask

  task automatic t_prst_stage();
    logic f;
    do_mrst(1'b0, 1'b1, 1'b1);
    wr(18'h111);
    pulse_prst();
    wr(18'h022);
    check("R8 staged byte dropped", {17'd0, core_we}, 18'd0);
    wr(18'h033);
    check("R8 new pair word", core_wdata, {9'h022, 9'h033});
    rd(f);
    idle(3);
    check("R8 single core write", 18'(wlog.size()), 18'd1);
    if (rlog.size() > 0) check("R8 config kept wide/big", rlog[0], {9'h022, 9'h033});
  endtask

  task automatic t_prst_unpack();
    logic f;
    do_mrst(1'b1, 1'b0, 1'b1);
    wr({9'h0A1, 9'h0B2});
    wr({9'h0C3, 9'h0D4});
    rd(f);
    idle(3);
    pulse_prst();
    rd(f);
    check("R8 read after prst fetches", {17'd0, f}, 18'd1);
    idle(3);
    check("R8 unpack reads", 18'(rlog.size()), 18'd2);
    if (rlog.size() == 2) begin
      check("R8 first byte before prst", rlog[0], 18'h0A1);
      check("R8 new word after prst", rlog[1], 18'h0C3);
    end
  endtask

  task automatic t_cfg_ignore();
    logic f;
    do_mrst(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    in_wide_sel = 1'b0; out_wide_sel = 1'b0; big_end_sel = 1'b0;
    wr(18'h3C35A);
    check("R2 input stays wide", {17'd0, core_we}, 18'd1);
    check("R2 word passes", core_wdata, 18'h3C35A);
    rd(f);
    idle(3);
    if (rlog.size() > 0) check("R2 output stays wide", rlog[0], 18'h3C35A);
    else check("R2 output stays wide", 18'h3FFFF, 18'h3C35A);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    mrst = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    mrst = 1'b0;
    t_wide();
    t_narrow_in(1'b1);
    t_narrow_in(1'b0);
    t_narrow_out(1'b1);
    t_narrow_out(1'b0);
    t_narrow_both(1'b1);
    t_narrow_both(1'b0);
    t_prst_stage();
    t_prst_unpack();
    t_cfg_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule